// File: doc/BRIEF.md
# Processor Presence Bitmap with Hotplug Event

This block holds one presence bit for each processor slot of the platform. The bit index of a slot is the processor's APIC ID. A platform-side request port marks slots as inserted or removed. Host software reads the map one byte at a time. Every accepted change also sets a sticky general-purpose event status bit, which drives the system control interrupt. That bit stays set until the host writes a one to its position.

For ordinary purposes the map is read-only, and host writes to it are dropped. There is one exception. Writing zero into each of the four bytes of the first 32-bit word moves the platform to the newer hotplug register interface, and that mode then holds until reset. Once the new mode is active, hotplug requests no longer touch the map or the event bit. They go out on a forwarding port that feeds the newer register block.

Top module: `cpu_presence_bank`

## Requirements
- R1: After reset the map reads all zero, the mode flag is 0 (legacy), the event bit is 0, and `host_rd_valid` and `fwd_valid` are 0.
- R2: In legacy mode a request with `hp_req_add`=1 sets bit (slot mod 8) of map byte (slot div 8). Reads see it from the cycle after the request.
- R3: In legacy mode a request with `hp_req_add`=0 clears that same bit. No other bit changes.
- R4: In legacy mode every request sets `gpe_cpu_evt` in the next cycle, whether or not the map bit changed.
- R5: `gpe_cpu_evt` stays set until a cycle with `gpe_wr_en`=1 and bit 2 of `gpe_wdata` at 1. Writes with bit 2 at 0 have no effect. If a legacy request and a clear fall in the same cycle, the bit stays set.
- R6: A read with `host_rd_en`=1 returns map byte `host_addr` on `host_rdata`, with `host_rd_valid`=1, exactly one cycle later. The data shows the map as it was before any change made in that same cycle. Offsets 32 and above read 0x00.
- R7: Host writes never change the map contents.
- R8: A zero write to each of offsets 0, 1, 2 and 3, in any order, sets the mode flag in the cycle after the last of them. A nonzero write to any of offsets 0 to 3 discards the zero writes collected so far. Writes to offsets 4 and above leave the collection untouched.
- R9: Once set, the mode flag stays set until reset, whatever the host writes.
- R10: In new mode a request leaves the map and `gpe_cpu_evt` unchanged. It appears one cycle later on `fwd_valid`, `fwd_slot` and `fwd_add`. In legacy mode `fwd_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_req_valid | input | 1 | Hotplug request strobe |
| hp_req_slot | input | 8 | Processor slot (APIC ID) of the request |
| hp_req_add | input | 1 | 1 = insert, 0 = remove |
| host_rd_en | input | 1 | Host byte read strobe |
| host_wr_en | input | 1 | Host byte write strobe |
| host_addr | input | 6 | Host byte offset into the map |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid with host_rd_valid |
| host_rd_valid | output | 1 | Read data valid |
| gpe_wr_en | input | 1 | Host write strobe to the event status byte |
| gpe_wdata | input | 8 | Event status write byte; a 1 in bit 2 clears |
| gpe_cpu_evt | output | 1 | Sticky processor hotplug event status |
| new_if_mode | output | 1 | 1 once the new interface mode is active |
| fwd_valid | output | 1 | Forwarded request strobe (new mode) |
| fwd_slot | output | 8 | Forwarded slot |
| fwd_add | output | 1 | Forwarded insert/remove flag |

## Verification
The assertions check the cycle-level rules on every cycle: each legacy request raises the event, the event holds until a qualifying clear, read strobes get a response one cycle later, the mode flag is sticky and changes only on a host write, and forwarding occurs only in new mode, with the request's slot and direction. Only the bench's scenarios can show the map's contents as seen through byte reads. They also show that host writes leave the map alone, that an interrupted zero-write sequence restarts, and that requests in new mode leave earlier presence bits in place.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;

    localparam int BITS_PER_BYTE = 8;
    localparam int SWITCH_BYTES  = 4;

    typedef struct packed {
        logic [SWITCH_BYTES-1:0] zero_seen;
        logic                    new_mode;
    } mode_state_t;

    typedef struct packed {
        logic pending;
    } evt_state_t;

endpackage

// File: rtl/cpuhp_bitmap.sv
module cpuhp_bitmap
    import cpuhp_pkg::*;
#(
    parameter int NUM_SLOTS = 256,
    parameter int HOST_AW   = 6,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int NUM_BYTES = NUM_SLOTS / BITS_PER_BYTE,
    localparam int BYTE_W   = $clog2(NUM_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_en,
    input  logic [SLOT_W-1:0]  upd_slot,
    input  logic               upd_add,
    input  logic               rd_en,
    input  logic [HOST_AW-1:0] rd_addr,
    output logic [7:0]         rd_data,
    output logic               rd_valid
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0] bits;
        logic [7:0]           rdata;
        logic                 rvalid;
    } map_state_t;

    map_state_t st_d, st_q;

    logic [7:0] lane [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        assign lane[g] = st_q.bits[g*BITS_PER_BYTE +: BITS_PER_BYTE];
    end

    logic             in_range;
    logic [BYTE_W-1:0] lane_idx;

    assign in_range = (rd_addr < HOST_AW'(NUM_BYTES));
    assign lane_idx = rd_addr[BYTE_W-1:0];

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_en;
        if (rd_en) begin
            st_d.rdata = in_range ? lane[lane_idx] : 8'h00;
        end
        if (upd_en) begin
            st_d.bits[upd_slot] = upd_add;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.rdata;
    assign rd_valid = st_q.rvalid;

endmodule

// File: rtl/cpuhp_mode_sw.sv
module cpuhp_mode_sw
    import cpuhp_pkg::*;
#(
    parameter int HOST_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [HOST_AW-1:0] wr_addr,
    input  logic [7:0]         wr_data,
    output logic               new_mode
);

    localparam int SEL_W = $clog2(SWITCH_BYTES);

    mode_state_t st_d, st_q;

    logic in_word;

    assign in_word = (wr_addr < HOST_AW'(SWITCH_BYTES));

    always_comb begin
        st_d = st_q;
        if (!st_q.new_mode && wr_en && in_word) begin
            if (wr_data == 8'h00) begin
                st_d.zero_seen[wr_addr[SEL_W-1:0]] = 1'b1;
            end else begin
                st_d.zero_seen = '0;
            end
            if (&st_d.zero_seen) begin
                st_d.new_mode = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign new_mode = st_q.new_mode;

endmodule

// File: rtl/cpuhp_evt.sv
module cpuhp_evt
    import cpuhp_pkg::*;
#(
    parameter int EVT_BIT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_evt,
    input  logic       clr_wr,
    input  logic [7:0] clr_data,
    output logic       sts
);

    evt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_wr && clr_data[EVT_BIT]) begin
            st_d.pending = 1'b0;
        end
        if (set_evt) begin
            st_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts = st_q.pending;

endmodule

// File: rtl/cpu_presence_bank.sv
module cpu_presence_bank
    import cpuhp_pkg::*;
#(
    parameter int NUM_SLOTS = 256,
    parameter int EVT_BIT   = 2,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int BYTE_W   = $clog2(NUM_SLOTS / BITS_PER_BYTE),
    localparam int HOST_AW  = BYTE_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hp_req_valid,
    input  logic [SLOT_W-1:0]  hp_req_slot,
    input  logic               hp_req_add,
    input  logic               host_rd_en,
    input  logic               host_wr_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    output logic               host_rd_valid,
    input  logic               gpe_wr_en,
    input  logic [7:0]         gpe_wdata,
    output logic               gpe_cpu_evt,
    output logic               new_if_mode,
    output logic               fwd_valid,
    output logic [SLOT_W-1:0]  fwd_slot,
    output logic               fwd_add
);

    typedef struct packed {
        logic              valid;
        logic [SLOT_W-1:0] slot;
        logic              add;
    } fwd_state_t;

    fwd_state_t fwd_d, fwd_q;

    logic mode_now;
    logic legacy_req;
    logic modern_req;

    assign legacy_req = hp_req_valid && !mode_now;
    assign modern_req = hp_req_valid &&  mode_now;

    cpuhp_mode_sw #(
        .HOST_AW (HOST_AW)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr_en),
        .wr_addr  (host_addr),
        .wr_data  (host_wdata),
        .new_mode (mode_now)
    );

    cpuhp_bitmap #(
        .NUM_SLOTS (NUM_SLOTS),
        .HOST_AW   (HOST_AW)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (legacy_req),
        .upd_slot (hp_req_slot),
        .upd_add  (hp_req_add),
        .rd_en    (host_rd_en),
        .rd_addr  (host_addr),
        .rd_data  (host_rdata),
        .rd_valid (host_rd_valid)
    );

    cpuhp_evt #(
        .EVT_BIT (EVT_BIT)
    ) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (legacy_req),
        .clr_wr   (gpe_wr_en),
        .clr_data (gpe_wdata),
        .sts      (gpe_cpu_evt)
    );

    always_comb begin
        fwd_d       = fwd_q;
        fwd_d.valid = modern_req;
        if (modern_req) begin
            fwd_d.slot = hp_req_slot;
            fwd_d.add  = hp_req_add;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_q <= '0;
        end else begin
            fwd_q <= fwd_d;
        end
    end

    assign new_if_mode = mode_now;
    assign fwd_valid   = fwd_q.valid;
    assign fwd_slot    = fwd_q.slot;
    assign fwd_add     = fwd_q.add;

endmodule

// File: rtl/cpuhp_chk.sv
module cpuhp_chk #(
    parameter int SLOT_W  = 8,
    parameter int EVT_BIT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hp_req_valid,
    input logic [SLOT_W-1:0] hp_req_slot,
    input logic              hp_req_add,
    input logic              host_rd_en,
    input logic              host_wr_en,
    input logic              host_rd_valid,
    input logic              gpe_wr_en,
    input logic [7:0]        gpe_wdata,
    input logic              gpe_cpu_evt,
    input logic              new_if_mode,
    input logic              fwd_valid,
    input logic [SLOT_W-1:0] fwd_slot,
    input logic              fwd_add
);

    a_r4_event_on_legacy_req: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_req_valid && !new_if_mode) |=> gpe_cpu_evt);

    a_r5_event_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (gpe_cpu_evt && !(gpe_wr_en && gpe_wdata[EVT_BIT])) |=> gpe_cpu_evt);

    a_r5_event_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (gpe_wr_en && gpe_wdata[EVT_BIT] && !(hp_req_valid && !new_if_mode)) |=> !gpe_cpu_evt);

    a_r6_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_en |=> host_rd_valid);

    a_r6_no_spurious_read: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_en |=> !host_rd_valid);

    a_r8_mode_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!new_if_mode && !host_wr_en) |=> !new_if_mode);

    a_r9_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        new_if_mode |=> new_if_mode);

    a_r10_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_req_valid && new_if_mode) |=>
            (fwd_valid && fwd_slot == $past(hp_req_slot) && fwd_add == $past(hp_req_add)));

    a_r10_no_fwd_in_legacy: assert property (@(posedge clk) disable iff (!rst_n)
        !new_if_mode |=> !fwd_valid);

    a_r10_no_event_in_new_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (new_if_mode && !gpe_cpu_evt) |=> !gpe_cpu_evt);

endmodule

bind cpu_presence_bank cpuhp_chk #(
    .SLOT_W  (SLOT_W),
    .EVT_BIT (EVT_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hp_req_valid  (hp_req_valid),
    .hp_req_slot   (hp_req_slot),
    .hp_req_add    (hp_req_add),
    .host_rd_en    (host_rd_en),
    .host_wr_en    (host_wr_en),
    .host_rd_valid (host_rd_valid),
    .gpe_wr_en     (gpe_wr_en),
    .gpe_wdata     (gpe_wdata),
    .gpe_cpu_evt   (gpe_cpu_evt),
    .new_if_mode   (new_if_mode),
    .fwd_valid     (fwd_valid),
    .fwd_slot      (fwd_slot),
    .fwd_add       (fwd_add)
);

// File: tb/sim_cpu_presence_bank.sv
module sim_cpu_presence_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOT      = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hp_req_valid = 1'b0;
    logic [7:0] hp_req_slot = '0;
    logic       hp_req_add = 1'b0;
    logic       host_rd_en = 1'b0;
    logic       host_wr_en = 1'b0;
    logic [5:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_rd_valid;
    logic       gpe_wr_en = 1'b0;
    logic [7:0] gpe_wdata = '0;
    logic       gpe_cpu_evt;
    logic       new_if_mode;
    logic       fwd_valid;
    logic [7:0] fwd_slot;
    logic       fwd_add;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_presence_bank u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .hp_req_valid  (hp_req_valid),
        .hp_req_slot   (hp_req_slot),
        .hp_req_add    (hp_req_add),
        .host_rd_en    (host_rd_en),
        .host_wr_en    (host_wr_en),
        .host_addr     (host_addr),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .host_rd_valid (host_rd_valid),
        .gpe_wr_en     (gpe_wr_en),
        .gpe_wdata     (gpe_wdata),
        .gpe_cpu_evt   (gpe_cpu_evt),
        .new_if_mode   (new_if_mode),
        .fwd_valid     (fwd_valid),
        .fwd_slot      (fwd_slot),
        .fwd_add       (fwd_add)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit reported = 1'b0;

    logic [NSLOT-1:0] model = '0;
    bit               model_new = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // monitor: pops one expected byte per returned read
    always @(negedge clk) begin
        if (rst_n && host_rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected read data", {24'h0, host_rdata}, 32'h0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(host_rdata === e, t, {24'h0, host_rdata}, {24'h0, e});
            end
        end
    end

    task automatic do_read(int a, string tag);
        @(negedge clk);
        host_rd_en = 1'b1;
        host_addr  = 6'(a);
        exp_q.push_back((a < NSLOT/8) ? model[a*8 +: 8] : 8'h00);
        tag_q.push_back(tag);
        @(negedge clk);
        host_rd_en = 1'b0;
    endtask

    task automatic do_plug(int slot, bit add);
        @(negedge clk);
        hp_req_valid = 1'b1;
        hp_req_slot  = 8'(slot);
        hp_req_add   = add;
        if (!model_new) model[slot] = add;
        @(negedge clk);
        hp_req_valid = 1'b0;
    endtask

    task automatic host_write(int a, logic [7:0] d);
        @(negedge clk);
        host_wr_en = 1'b1;
        host_addr  = 6'(a);
        host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic gpe_write(logic [7:0] d);
        @(negedge clk);
        gpe_wr_en = 1'b1;
        gpe_wdata = d;
        @(negedge clk);
        gpe_wr_en = 1'b0;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6 read responses missing", exp_q.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(new_if_mode == 1'b0, "R1 mode after reset", new_if_mode, 0);
        check(gpe_cpu_evt == 1'b0, "R1 event after reset", gpe_cpu_evt, 0);
        check(host_rd_valid == 1'b0, "R1 rd_valid after reset", host_rd_valid, 0);
        check(fwd_valid == 1'b0, "R1 fwd_valid after reset", fwd_valid, 0);
        for (int a = 0; a < NSLOT/8; a++) do_read(a, "R1 map zero after reset");
        drain();

        // R2/R4: inserts across bytes
        do_plug(0, 1'b1);
        check(gpe_cpu_evt == 1'b1, "R4 event after insert", gpe_cpu_evt, 1);
        check(fwd_valid == 1'b0, "R10 no forward in legacy", fwd_valid, 0);
        do_plug(9, 1'b1);
        do_plug(130, 1'b1);
        do_plug(255, 1'b1);
        do_plug(10, 1'b1);
        do_read(0, "R2 byte 0");
        do_read(1, "R2 byte 1");
        do_read(16, "R2 byte 16");
        do_read(31, "R2 byte 31");
        drain();

        // R5: clear rules
        gpe_write(8'hFB);
        check(gpe_cpu_evt == 1'b1, "R5 clear without bit 2 ignored", gpe_cpu_evt, 1);
        gpe_write(8'h04);
        check(gpe_cpu_evt == 1'b0, "R5 clear with bit 2", gpe_cpu_evt, 0);
        @(negedge clk);
        check(gpe_cpu_evt == 1'b0, "R5 stays clear", gpe_cpu_evt, 0);

        // R3 and R4: remove raises event even if bit already clear
        do_plug(9, 1'b0);
        check(gpe_cpu_evt == 1'b1, "R4 event after remove", gpe_cpu_evt, 1);
        do_read(1, "R3 byte 1 after remove");
        gpe_write(8'h04);
        do_plug(77, 1'b0);
        check(gpe_cpu_evt == 1'b1, "R4 event on no-change remove", gpe_cpu_evt, 1);
        drain();

        // R5: set wins over same-cycle clear
        @(negedge clk);
        gpe_wr_en    = 1'b1;
        gpe_wdata    = 8'h04;
        hp_req_valid = 1'b1;
        hp_req_slot  = 8'd40;
        hp_req_add   = 1'b1;
        model[40]    = 1'b1;
        @(negedge clk);
        gpe_wr_en    = 1'b0;
        hp_req_valid = 1'b0;
        check(gpe_cpu_evt == 1'b1, "R5 set wins over clear", gpe_cpu_evt, 1);

        // R6: read during same-cycle update returns old value; out of range
        @(negedge clk);
        host_rd_en   = 1'b1;
        host_addr    = 6'd5;
        exp_q.push_back(model[40 +: 8]);
        tag_q.push_back("R6 read sees pre-update byte");
        hp_req_valid = 1'b1;
        hp_req_slot  = 8'd41;
        hp_req_add   = 1'b1;
        model[41]    = 1'b1;
        @(negedge clk);
        host_rd_en   = 1'b0;
        hp_req_valid = 1'b0;
        do_read(5, "R6 byte 5 after update");
        do_read(40, "R6 out of range reads zero");
        do_read(63, "R6 top offset reads zero");
        drain();

        // R7: writes do not alter the map
        host_write(1, 8'hFF);
        host_write(16, 8'h00);
        host_write(31, 8'h5A);
        host_write(0, 8'hFF);
        do_read(1, "R7 byte 1 unchanged");
        do_read(16, "R7 byte 16 unchanged");
        do_read(31, "R7 byte 31 unchanged");
        do_read(0, "R7 byte 0 unchanged");
        drain();

        // R8: interrupted sequence restarts
        host_write(0, 8'h00);
        host_write(1, 8'h00);
        host_write(2, 8'h00);
        host_write(7, 8'h33);
        host_write(3, 8'h01);
        check(new_if_mode == 1'b0, "R8 nonzero write blocks switch", new_if_mode, 0);
        host_write(3, 8'h00);
        host_write(1, 8'h00);
        host_write(0, 8'h00);
        check(new_if_mode == 1'b0, "R8 three zero bytes not enough", new_if_mode, 0);
        host_write(12, 8'hAA);
        host_write(2, 8'h00);
        check(new_if_mode == 1'b1, "R8 switch after fourth zero byte", new_if_mode, 1);
        model_new = 1'b1;
        do_read(0, "R7 switch writes leave map");
        drain();

        // R10: requests forwarded, map and event frozen
        gpe_write(8'h04);
        do_plug(50, 1'b1);
        check(fwd_valid == 1'b1, "R10 forward strobe", fwd_valid, 1);
        check(fwd_slot == 8'd50, "R10 forward slot", fwd_slot, 50);
        check(fwd_add == 1'b1, "R10 forward add", fwd_add, 1);
        check(gpe_cpu_evt == 1'b0, "R10 no event in new mode", gpe_cpu_evt, 0);
        do_plug(0, 1'b0);
        check(fwd_valid == 1'b1 && fwd_add == 1'b0 && fwd_slot == 8'd0,
              "R10 forward remove", {fwd_valid, fwd_add, fwd_slot}, 32'h200);
        @(negedge clk);
        check(fwd_valid == 1'b0, "R10 forward strobe drops", fwd_valid, 0);
        do_read(6, "R10 byte 6 unchanged");
        do_read(0, "R10 byte 0 keeps insert");
        drain();

        // R9: mode sticky against further writes
        host_write(0, 8'hFF);
        host_write(3, 8'h12);
        @(negedge clk);
        check(new_if_mode == 1'b1, "R9 mode sticky", new_if_mode, 1);

        // R1: reset returns to legacy with cleared map
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        model_new = 1'b0;
        check(new_if_mode == 1'b0, "R1 mode after second reset", new_if_mode, 0);
        do_read(0, "R1 map cleared after second reset");
        do_read(31, "R1 map cleared after second reset");
        drain();

        report();
    end

endmodule